// File: doc/BRIEF.md
# Rate-Limited Clear-On-Read Interrupt Controller

This block gathers eight event causes into a status register and drives an active-low interrupt line toward a host processor. Level inputs (temperature warning, ground-offset warning, a four-bit bus fault code, a set of supply-good flags, a battery sense line) are turned into one-cycle events by change detection inside the block. Pulse inputs (serial-frame error, wake-up, watchdog overflow) are taken as events directly. Each cause has an enable bit, held in a local enable register. An event whose enable is clear is neither recorded nor signalled.

Two causes, the serial-frame error and the battery drop, are urgent: they pull the line low as soon as they are recorded. The other six are recorded at once. In normal mode they may start an interrupt at most once per watchdog period. Outside normal mode they act like urgent causes. The host reads the status through a read strobe. That read clears every bit except those whose events arrive in the read cycle. It also releases the line for a fixed number of cycles, so that any later assertion gives a fresh falling edge.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Reset (rst_n low at a clock edge) clears the status to 0 and the enables to 0, and leaves intn_o high.
- R2: An event on a source whose enable bit is 0 sets no status bit and does not lower intn_o.
- R3: Status bit positions are: 0 serial-frame error, 1 battery drop, 2 temperature warning, 3 ground offset, 4 bus fault code, 5 supply failure, 6 wake-up, 7 watchdog overflow. An enabled event is visible on stat_o after the next clock edge, and the bit stays set until a read. stat_o during the read cycle gives the value being read.
- R4: A read clears every status bit. The exception is a bit whose enabled event occurs in the read cycle itself: that bit is set after the read.
- R5: When no release time is running, a recorded urgent cause (bit 0 or 1) lowers intn_o on the second clock edge after its event, in any mode.
- R6: With norm_mode_i high, non-urgent causes start at most one interrupt per watchdog period. Once one has done so, later non-urgent causes stay recorded but leave intn_o high until the next wd_tick_i. They then lower intn_o on the edge after that tick.
- R7: With norm_mode_i low, non-urgent causes lower intn_o with the same latency as urgent ones.
- R8: A read drives intn_o high from the read edge onward. It stays high for at least REL_CYC further edges. If a cause is still pending, it falls on exactly edge REL_CYC+1 after the read edge.
- R9: The temperature and ground-offset inputs give an event on both rising and falling changes. The fault code gives an event on any change of value. The supply source gives an event when any supply-good flag goes 1 to 0, and none on 0 to 1. The battery sense gives an event on a falling edge only.
- R10: Every watchdog overflow clears enable bit 7 on the same edge, taking priority over a write. The overflow that clears it is still recorded if the bit was set.
- R11: A write strobe loads all enable bits from en_wdata_i. The new value shows on en_o after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| en_o | output | 8 | Enable register readback |
| rd_i | input | 1 | Status read strobe (clears status) |
| stat_o | output | 8 | Status register contents |
| norm_mode_i | input | 1 | High while in normal mode (throttle active) |
| wd_tick_i | input | 1 | One-cycle pulse at each watchdog period boundary |
| wd_ovf_i | input | 1 | One-cycle watchdog overflow pulse |
| spi_err_i | input | 1 | One-cycle serial-frame length error pulse |
| bat_sense_i | input | 1 | Battery sense level (falling edge is an event) |
| otemp_i | input | 1 | Temperature warning level |
| gshift_i | input | 1 | Ground-offset warning level |
| can_code_i | input | CAN_W | Bus fault diagnosis code |
| sup_ok_i | input | SUP_N | Supply-good flags, one per regulator |
| wake_i | input | 1 | One-cycle wake-up pulse |
| intn_o | output | 1 | Active-low interrupt line |

## Verification
The assertions take the pulse inputs (read strobe, watchdog tick, overflow, frame error, wake-up) to be single-cycle strobes from synchronous logic. They take level inputs to be already synchronised to clk. In the enable-register check they also take it that a write and an overflow may meet in one cycle. The stimulus drives every input on the falling clock edge, pulses strobes for exactly one cycle, and holds level inputs at their reset values whenever reset is applied. No check therefore rests on edge ordering or on a change detected across reset.

// File: rtl/evt_irq_pkg.sv
// Shared source indices, vector type and urgency set for the interrupt controller.
// Assumes eight causes; the bit order is visible to software and fixed.
package evt_irq_pkg;
    localparam int NSRC     = 8;
    localparam int SRC_SPI  = 0;
    localparam int SRC_BAT  = 1;
    localparam int SRC_TEMP = 2;
    localparam int SRC_GND  = 3;
    localparam int SRC_CAN  = 4;
    localparam int SRC_SUP  = 5;
    localparam int SRC_WAKE = 6;
    localparam int SRC_WDT  = 7;

    typedef logic [NSRC-1:0] src_vec_t;

    localparam src_vec_t URGENT_SET = src_vec_t'((1 << SRC_SPI) | (1 << SRC_BAT));
endpackage

// File: rtl/irq_src_detect.sv
// Turns raw cause inputs into one-cycle event pulses.
// Pulse inputs pass straight through; level inputs are compared with their
// registered previous value. Assumes all inputs are synchronous to clk and
// sit at their reset values (sense high, supplies good, rest low) during reset.
module irq_src_detect
    import evt_irq_pkg::*;
#(
    parameter int CAN_W = 4,
    parameter int SUP_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_err_i,
    input  logic             wake_i,
    input  logic             wd_ovf_i,
    input  logic             bat_sense_i,
    input  logic             otemp_i,
    input  logic             gshift_i,
    input  logic [CAN_W-1:0] can_code_i,
    input  logic [SUP_N-1:0] sup_ok_i,
    output src_vec_t         raw_o
);
    logic             bat_q;
    logic             temp_q;
    logic             gnd_q;
    logic [CAN_W-1:0] can_q;
    logic [SUP_N-1:0] sup_q;
    logic [SUP_N-1:0] sup_fall;

    // Remember last value of every level input for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bat_q  <= 1'b1;
            temp_q <= 1'b0;
            gnd_q  <= 1'b0;
            can_q  <= '0;
            sup_q  <= '1;
        end else begin
            bat_q  <= bat_sense_i;
            temp_q <= otemp_i;
            gnd_q  <= gshift_i;
            can_q  <= can_code_i;
            sup_q  <= sup_ok_i;
        end
    end

    // Per-regulator good-to-bad transition.
    for (genvar g = 0; g < SUP_N; g++) begin : g_sup
        assign sup_fall[g] = sup_q[g] & ~sup_ok_i[g];
    end

    // Assemble the event vector in status bit order.
    always_comb begin
        raw_o           = '0;
        raw_o[SRC_SPI]  = spi_err_i;
        raw_o[SRC_BAT]  = bat_q & ~bat_sense_i;
        raw_o[SRC_TEMP] = temp_q ^ otemp_i;
        raw_o[SRC_GND]  = gnd_q ^ gshift_i;
        raw_o[SRC_CAN]  = can_q != can_code_i;
        raw_o[SRC_SUP]  = |sup_fall;
        raw_o[SRC_WAKE] = wake_i;
        raw_o[SRC_WDT]  = wd_ovf_i;
    end
endmodule

// File: rtl/irq_enable_reg.sv
// Per-cause enable register, written whole by a strobe.
// The watchdog-overflow enable drops on every overflow, overriding a write.
module irq_enable_reg
    import evt_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_i,
    input  src_vec_t wdata_i,
    input  logic     wd_ovf_i,
    output src_vec_t en_o
);
    src_vec_t en_q;

    // Load on write; overflow then forces the watchdog enable low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            if (wr_i)     en_q <= wdata_i;
            if (wd_ovf_i) en_q[SRC_WDT] <= 1'b0;
        end
    end

    assign en_o = en_q;

    // R10
    wdt_en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_ovf_i |=> !en_q[SRC_WDT]);

    // R11
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wd_ovf_i) |=> (en_q == $past(wdata_i)));
endmodule

// File: rtl/irq_status_reg.sv
// Sticky status register with clear-on-read.
// Events gated by their enables accumulate; a read replaces the contents with
// only the events of the read cycle, so none is lost across the clear.
module irq_status_reg
    import evt_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t raw_i,
    input  src_vec_t en_i,
    input  logic     rd_i,
    output src_vec_t stat_o
);
    src_vec_t stat_q;
    src_vec_t evt_g;

    assign evt_g = raw_i & en_i;

    // Accumulate events; on read keep only the concurrent ones.
    always_ff @(posedge clk) begin
        if (!rst_n)    stat_q <= '0;
        else if (rd_i) stat_q <= evt_g;
        else           stat_q <= stat_q | evt_g;
    end

    assign stat_o = stat_q;

    // R4
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> ((stat_q & ~$past(evt_g)) == '0));

    // R4
    rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> ((stat_q & $past(evt_g)) == $past(evt_g)));

    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/irq_pin_ctrl.sv
// Drives the active-low interrupt line from the status contents.
// Urgent causes launch at once; non-urgent ones launch once per watchdog
// period in normal mode. A read releases the line and blocks any launch for
// REL_CYC cycles. Assumes wd_tick_i and rd_i are single-cycle strobes.
module irq_pin_ctrl
    import evt_irq_pkg::*;
#(
    parameter int unsigned REL_CYC  = 8,
    parameter src_vec_t    URG_MASK = URGENT_SET
) (
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t stat_i,
    input  logic     rd_i,
    input  logic     norm_i,
    input  logic     wd_tick_i,
    output logic     intn_o
);
    localparam int REL_W = $clog2(REL_CYC + 1);

    logic             irq_q;
    logic             spent_q;
    logic [REL_W-1:0] rel_q;
    logic             pend_urg;
    logic             pend_nu;
    logic             launch;

    assign pend_urg = |(stat_i & URG_MASK);
    assign pend_nu  = |(stat_i & ~URG_MASK);
    assign launch   = !irq_q && !rd_i && (rel_q == '0) &&
                      (pend_urg || (pend_nu && (!norm_i || !spent_q)));

    // Interrupt state: set by a launch, held until a read.
    always_ff @(posedge clk) begin
        if (!rst_n || rd_i) irq_q <= 1'b0;
        else if (launch)    irq_q <= 1'b1;
    end

    // Release timer: loaded by a read, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             rel_q <= '0;
        else if (rd_i)          rel_q <= REL_W'(REL_CYC);
        else if (rel_q != '0)   rel_q <= rel_q - 1'b1;
    end

    // Throttle flag: marks a non-urgent launch in normal mode, rearmed by tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                          spent_q <= 1'b0;
        else if (launch && norm_i && pend_nu) spent_q <= 1'b1;
        else if (wd_tick_i)                  spent_q <= 1'b0;
    end

    assign intn_o = ~irq_q;

    // R8
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> intn_o);

    // R8
    rel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_q != '0) |=> intn_o);

    // R6
    throttle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_i && spent_q && intn_o && !pend_urg) |=> intn_o);

    // R5
    urgent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_urg && intn_o && !rd_i && (rel_q == '0)) |=> !intn_o);
endmodule

// File: rtl/evt_irq_ctrl.sv
// Top of the rate-limited clear-on-read interrupt controller.
// Wires change detection, enable register, status register and line control.
// Assumes all inputs are synchronous to clk; strobes last one cycle.
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int          CAN_W   = 4,
    parameter int          SUP_N   = 3,
    parameter int unsigned REL_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr_i,
    input  logic [NSRC-1:0]  en_wdata_i,
    output logic [NSRC-1:0]  en_o,
    input  logic             rd_i,
    output logic [NSRC-1:0]  stat_o,
    input  logic             norm_mode_i,
    input  logic             wd_tick_i,
    input  logic             wd_ovf_i,
    input  logic             spi_err_i,
    input  logic             bat_sense_i,
    input  logic             otemp_i,
    input  logic             gshift_i,
    input  logic [CAN_W-1:0] can_code_i,
    input  logic [SUP_N-1:0] sup_ok_i,
    input  logic             wake_i,
    output logic             intn_o
);
    src_vec_t raw;
    src_vec_t en;
    src_vec_t stat;

    irq_src_detect #(.CAN_W(CAN_W), .SUP_N(SUP_N)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_err_i   (spi_err_i),
        .wake_i      (wake_i),
        .wd_ovf_i    (wd_ovf_i),
        .bat_sense_i (bat_sense_i),
        .otemp_i     (otemp_i),
        .gshift_i    (gshift_i),
        .can_code_i  (can_code_i),
        .sup_ok_i    (sup_ok_i),
        .raw_o       (raw)
    );

    irq_enable_reg u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (en_wr_i),
        .wdata_i  (en_wdata_i),
        .wd_ovf_i (wd_ovf_i),
        .en_o     (en)
    );

    irq_status_reg u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw),
        .en_i   (en),
        .rd_i   (rd_i),
        .stat_o (stat)
    );

    irq_pin_ctrl #(.REL_CYC(REL_CYC), .URG_MASK(URGENT_SET)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_i    (stat),
        .rd_i      (rd_i),
        .norm_i    (norm_mode_i),
        .wd_tick_i (wd_tick_i),
        .intn_o    (intn_o)
    );

    assign en_o   = en;
    assign stat_o = stat;

    // R2
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && (stat == '0) && ((raw & en) == '0)) |=> (stat_o == '0));
endmodule

// File: tb/evt_irq_ctrl_tb.sv
// Directed bench for the interrupt controller: one task per scenario.
module evt_irq_ctrl_tb;
    localparam int REL = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_wr_i = 1'b0;
    logic [7:0] en_wdata_i = '0;
    logic [7:0] en_o;
    logic       rd_i = 1'b0;
    logic [7:0] stat_o;
    logic       norm_mode_i = 1'b0;
    logic       wd_tick_i = 1'b0;
    logic       wd_ovf_i = 1'b0;
    logic       spi_err_i = 1'b0;
    logic       bat_sense_i = 1'b1;
    logic       otemp_i = 1'b0;
    logic       gshift_i = 1'b0;
    logic [3:0] can_code_i = '0;
    logic [2:0] sup_ok_i = 3'b111;
    logic       wake_i = 1'b0;
    logic       intn_o;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    evt_irq_ctrl #(.CAN_W(4), .SUP_N(3), .REL_CYC(REL)) u_dut (.*);

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_read(output logic [7:0] val);
        val  = stat_o;
        rd_i = 1'b1;
        step(1);
        rd_i = 1'b0;
    endtask

    task automatic clear_all();
        logic [7:0] v;
        do_read(v);
        step(REL + 2);
    endtask

    task automatic t_reset();
        check("R1 intn after reset", intn_o, 1);
        check("R1 status after reset", stat_o, 0);
        check("R1 enables after reset", en_o, 0);
    endtask

    task automatic t_disabled();
        spi_err_i = 1'b1; step(1); spi_err_i = 1'b0;
        otemp_i = 1'b1;   step(2); otemp_i = 1'b0; step(2);
        check("R2 disabled status", stat_o, 0);
        check("R2 disabled intn", intn_o, 1);
        en_wr_i = 1'b1; en_wdata_i = 8'hFF; step(1); en_wr_i = 1'b0;
        check("R11 enable write", en_o, 8'hFF);
    endtask

    task automatic t_urgent_race();
        logic [7:0] v;
        spi_err_i = 1'b1; step(1); spi_err_i = 1'b0;
        check("R3 spi bit recorded", stat_o, 8'h01);
        check("R5 not yet asserted", intn_o, 1);
        step(1);
        check("R5 urgent asserts", intn_o, 0);
        bat_sense_i = 1'b0;
        do_read(v);
        check("R3 read data", v, 8'h01);
        check("R4 concurrent event kept", stat_o, 8'h02);
        check("R8 released at read", intn_o, 1);
        for (int k = 1; k <= REL; k++) begin
            step(1);
            check("R8 release held", intn_o, 1);
        end
        step(1);
        check("R8 reassert after release", intn_o, 0);
        bat_sense_i = 1'b1;
        do_read(v);
        check("R4 read clears", stat_o, 0);
        step(REL + 2);
        check("R9 battery rise no event", intn_o, 1);
    endtask

    task automatic t_throttle();
        norm_mode_i = 1'b1;
        otemp_i = 1'b1; step(1);
        check("R9 temp rise event", stat_o, 8'h04);
        step(1);
        check("R6 first non-urgent asserts", intn_o, 0);
        clear_all();
        gshift_i = 1'b1; step(1);
        check("R3 recorded while throttled", stat_o, 8'h08);
        step(20);
        check("R6 throttled", intn_o, 1);
        wd_tick_i = 1'b1; step(1); wd_tick_i = 1'b0;
        check("R6 not before tick+1", intn_o, 1);
        step(1);
        check("R6 asserts after tick", intn_o, 0);
        clear_all();
        spi_err_i = 1'b1; step(1); spi_err_i = 1'b0; step(1);
        check("R5 urgent not throttled", intn_o, 0);
        clear_all();
    endtask

    task automatic t_nonnorm();
        norm_mode_i = 1'b0;
        gshift_i = 1'b0; step(1);
        check("R9 ground fall event", stat_o, 8'h08);
        step(1);
        check("R7 immediate outside normal", intn_o, 0);
        clear_all();
    endtask

    task automatic t_sources();
        can_code_i = 4'd5; step(1);
        check("R9 code change", stat_o, 8'h10);
        step(3);
        clear_all();
        check("R9 steady code no event", stat_o, 0);
        sup_ok_i = 3'b101; step(1);
        check("R9 supply fail", stat_o, 8'h20);
        clear_all();
        sup_ok_i = 3'b111; step(2);
        check("R9 supply recover no event", stat_o, 0);
        wake_i = 1'b1; step(1); wake_i = 1'b0;
        check("R3 wake bit", stat_o, 8'h40);
        clear_all();
    endtask

    task automatic t_wdt();
        wd_ovf_i = 1'b1; en_wr_i = 1'b1; en_wdata_i = 8'hFF; step(1);
        wd_ovf_i = 1'b0; en_wr_i = 1'b0;
        check("R10 overflow beats write", en_o, 8'h7F);
        check("R10 overflow recorded", stat_o, 8'h80);
        clear_all();
        wd_ovf_i = 1'b1; step(1); wd_ovf_i = 1'b0;
        check("R2 overflow after self-clear", stat_o, 0);
        step(1);
        check("R2 no interrupt", intn_o, 1);
    endtask

    task automatic t_reset_clear();
        spi_err_i = 1'b1; step(1); spi_err_i = 1'b0; step(1);
        check("R5 pending before reset", intn_o, 0);
        rst_n = 1'b0; otemp_i = 1'b0; can_code_i = '0;
        step(2);
        rst_n = 1'b1;
        step(1);
        check("R1 reset clears status", stat_o, 0);
        check("R1 reset releases intn", intn_o, 1);
        check("R1 reset clears enables", en_o, 0);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_disabled();
        t_urgent_race();
        t_throttle();
        t_nonnorm();
        t_sources();
        t_wdt();
        t_reset_clear();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hang expected completion");
        summary();
        $finish;
    end
endmodule